// File: doc/BRIEF.md
# Two-Partition TDM Channel Selector

This block tells a serial port, slot by slot, whether a channel of a time-division multiplexed frame is one it should handle. A frame holds up to 128 channels, grouped into eight blocks of sixteen consecutive channels. Two partitions, A and B, each own one block: a 3-bit select per partition names the block. Partition A can only take an even block and partition B only an odd one. A 16-bit mask per partition then picks the active channels inside that block.

After a frame-sync pulse, the block counts the bits of each slot and then the slots of the frame. Ownership alternates between the partitions: A first, then B, A, B and so on, moving on at each 16-channel boundary. A slot is enabled only when its block is the one the owning partition has selected and that partition's mask bit for the channel is set. The receive and transmit sides each have a complete, independent copy of this logic, with their own strobe, sync and configuration.

Top module: `tdm_two_part_sel`

## Requirements
- R1: While reset is held and after it is released, each direction reports `active`=0, `ch_num`=0, `part_b`=0 and `ch_en`=0.
- R2: A cycle with `bit_en`=1 and `fsync`=1 starts a frame. From the next clock on, `active`=1, `ch_num`=0 and `part_b`=0 (partition A).
- R3: Only cycles with `bit_en`=1 are counted as bits. After `word_len_m1`+1 counted bits, `ch_num` goes up by one. Cycles with `bit_en`=0 leave `active`, `ch_num` and `part_b` unchanged.
- R4: `part_b` is 0 for channels 0–15, 1 for 16–31, 0 for 32–47 and so on. It alternates at each 16-channel boundary, so it always equals bit 4 of `ch_num` while `active`=1.
- R5: After the last bit of channel `frame_len_m1`, `active` drops to 0. While `active`=0, `ch_en` is 0.
- R6: A frame sync that arrives mid-frame restarts counting at channel 0, bit 0, partition A, whatever the partition was before.
- R7: Partition A owns block 2·`blk_a`[2:1] and partition B owns block 2·`blk_b`[2:1]+1. Bit 0 of each select has no effect. For a channel in an owned block, `ch_en` equals bit (`ch_num` mod 16) of that partition's mask.
- R8: Channels in blocks that neither partition selects have `ch_en`=0, whatever the masks hold.
- R9: Receive and transmit sides are independent. Activity on one side leaves the other side's outputs unchanged.
- R10: `fsync`=1 in a cycle with `bit_en`=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit_en | input | 1 | Receive bit strobe |
| rx_fsync | input | 1 | Receive frame sync, qualified by rx_bit_en |
| rx_word_len_m1 | input | 5 | Receive bits per slot minus one |
| rx_frame_len_m1 | input | 7 | Receive channels per frame minus one |
| rx_blk_a | input | 3 | Receive partition A block select (bit 0 unused) |
| rx_blk_b | input | 3 | Receive partition B block select (bit 0 unused) |
| rx_mask_a | input | 16 | Receive partition A channel mask |
| rx_mask_b | input | 16 | Receive partition B channel mask |
| rx_active | output | 1 | Receive frame in progress |
| rx_ch_num | output | 7 | Receive current channel |
| rx_part_b | output | 1 | Receive current partition (1 = B) |
| rx_ch_en | output | 1 | Receive current slot enabled |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_fsync | input | 1 | Transmit frame sync, qualified by tx_bit_en |
| tx_word_len_m1 | input | 5 | Transmit bits per slot minus one |
| tx_frame_len_m1 | input | 7 | Transmit channels per frame minus one |
| tx_blk_a | input | 3 | Transmit partition A block select (bit 0 unused) |
| tx_blk_b | input | 3 | Transmit partition B block select (bit 0 unused) |
| tx_mask_a | input | 16 | Transmit partition A channel mask |
| tx_mask_b | input | 16 | Transmit partition B channel mask |
| tx_active | output | 1 | Transmit frame in progress |
| tx_ch_num | output | 7 | Transmit current channel |
| tx_part_b | output | 1 | Transmit current partition (1 = B) |
| tx_ch_en | output | 1 | Transmit current slot enabled |

## Verification
A counting cycle (`bit_en`=1) at one rising edge changes `active`, `ch_num` and `part_b` at that same edge. Those values are therefore due one clock after the strobe was driven. `ch_en` is combinational from those registers and the select and mask inputs, so it reflects a configuration change within the same cycle. The bench drives inputs on the falling edge and compares every output on the following falling edge. It keeps a bit index that advances only when a strobe was driven, and derives the expected channel, partition and enable from that index by division and modulo.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int MAX_CH   = 128;
  localparam int BLK_SZ   = 16;
  localparam int CH_W     = $clog2(MAX_CH);
  localparam int OFF_W    = $clog2(BLK_SZ);
  localparam int BLK_W    = CH_W - OFF_W;
  localparam int WL_W     = 5;

  typedef logic [CH_W-1:0]   ch_t;
  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [BLK_SZ-1:0] mask_t;

  // block index of a channel
  function automatic blk_t blk_of(input ch_t ch);
    return ch[CH_W-1:OFF_W];
  endfunction

  // block owned by a partition: A forced even, B forced odd
  function automatic blk_t part_block(input blk_t sel, input logic is_b);
    return {sel[BLK_W-1:1], is_b};
  endfunction

  // slot enable for a channel given the owning partition
  function automatic logic slot_enable(input ch_t ch, input logic is_b,
                                       input blk_t sel_a, input blk_t sel_b,
                                       input mask_t m_a, input mask_t m_b);
    blk_t  want;
    mask_t m;
    want = is_b ? part_block(sel_b, 1'b1) : part_block(sel_a, 1'b0);
    m    = is_b ? m_b : m_a;
    return (blk_of(ch) == want) && m[ch[OFF_W-1:0]];
  endfunction
endpackage

// File: rtl/tps_slot_ctr.sv
module tps_slot_ctr
  import tps_pkg::*;
#(
  parameter int WLW = WL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           fsync,
  input  logic [WLW-1:0] word_len_m1,
  input  ch_t            frame_len_m1,
  output logic           active,
  output ch_t            ch_num,
  output logic           part_b,
  output logic           slot_last,
  output logic           frame_last,
  output logic           blk_wrap
);
  logic [WLW-1:0] bit_cnt;

  assign slot_last  = active && (bit_cnt >= word_len_m1);
  assign frame_last = slot_last && (ch_num >= frame_len_m1);
  assign blk_wrap   = slot_last && (ch_num[OFF_W-1:0] == OFF_W'(BLK_SZ-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      ch_num  <= '0;
      bit_cnt <= '0;
      part_b  <= 1'b0;
    end else if (bit_en) begin
      if (fsync) begin
        active  <= 1'b1;
        ch_num  <= '0;
        bit_cnt <= '0;
        part_b  <= 1'b0;
      end else if (active) begin
        if (slot_last) begin
          bit_cnt <= '0;
          if (frame_last) begin
            active <= 1'b0;
          end else begin
            ch_num <= ch_num + 1'b1;
            if (blk_wrap) part_b <= ~part_b;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tps_part_dec.sv
module tps_part_dec
  import tps_pkg::*;
(
  input  logic  active,
  input  ch_t   ch_num,
  input  logic  part_b,
  input  blk_t  blk_a,
  input  blk_t  blk_b,
  input  mask_t mask_a,
  input  mask_t mask_b,
  output logic  ch_en
);
  assign ch_en = active && slot_enable(ch_num, part_b, blk_a, blk_b, mask_a, mask_b);
endmodule

// File: rtl/tps_dir.sv
module tps_dir
  import tps_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            fsync,
  input  logic [WL_W-1:0] word_len_m1,
  input  ch_t             frame_len_m1,
  input  blk_t            blk_a,
  input  blk_t            blk_b,
  input  mask_t           mask_a,
  input  mask_t           mask_b,
  output logic            active,
  output ch_t             ch_num,
  output logic            part_b,
  output logic            ch_en
);
  logic slot_last, frame_last, blk_wrap;

  tps_slot_ctr #(.WLW(WL_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .word_len_m1(word_len_m1), .frame_len_m1(frame_len_m1),
    .active(active), .ch_num(ch_num), .part_b(part_b),
    .slot_last(slot_last), .frame_last(frame_last), .blk_wrap(blk_wrap)
  );

  tps_part_dec u_dec (
    .active(active), .ch_num(ch_num), .part_b(part_b),
    .blk_a(blk_a), .blk_b(blk_b), .mask_a(mask_a), .mask_b(mask_b),
    .ch_en(ch_en)
  );
endmodule

// File: rtl/tdm_two_part_sel.sv
module tdm_two_part_sel
  import tps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_bit_en,
  input  logic        rx_fsync,
  input  logic [4:0]  rx_word_len_m1,
  input  logic [6:0]  rx_frame_len_m1,
  input  logic [2:0]  rx_blk_a,
  input  logic [2:0]  rx_blk_b,
  input  logic [15:0] rx_mask_a,
  input  logic [15:0] rx_mask_b,
  output logic        rx_active,
  output logic [6:0]  rx_ch_num,
  output logic        rx_part_b,
  output logic        rx_ch_en,
  input  logic        tx_bit_en,
  input  logic        tx_fsync,
  input  logic [4:0]  tx_word_len_m1,
  input  logic [6:0]  tx_frame_len_m1,
  input  logic [2:0]  tx_blk_a,
  input  logic [2:0]  tx_blk_b,
  input  logic [15:0] tx_mask_a,
  input  logic [15:0] tx_mask_b,
  output logic        tx_active,
  output logic [6:0]  tx_ch_num,
  output logic        tx_part_b,
  output logic        tx_ch_en
);
  // R9: each direction has its own independent selector
  tps_dir u_rx (
    .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .fsync(rx_fsync),
    .word_len_m1(rx_word_len_m1), .frame_len_m1(rx_frame_len_m1),
    .blk_a(rx_blk_a), .blk_b(rx_blk_b), .mask_a(rx_mask_a), .mask_b(rx_mask_b),
    .active(rx_active), .ch_num(rx_ch_num), .part_b(rx_part_b), .ch_en(rx_ch_en)
  );

  tps_dir u_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(tx_bit_en), .fsync(tx_fsync),
    .word_len_m1(tx_word_len_m1), .frame_len_m1(tx_frame_len_m1),
    .blk_a(tx_blk_a), .blk_b(tx_blk_b), .mask_a(tx_mask_a), .mask_b(tx_mask_b),
    .active(tx_active), .ch_num(tx_ch_num), .part_b(tx_part_b), .ch_en(tx_ch_en)
  );
endmodule

// File: rtl/tps_chk.sv
module tps_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       fsync,
  input logic       active,
  input logic [6:0] ch_num,
  input logic       part_b,
  input logic       ch_en
);
  p_fsync_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && fsync |=> active && (ch_num == 7'd0) && !part_b);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ch_num) && $stable(active) && $stable(part_b));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active && $past(active) && (ch_num != $past(ch_num))
      |-> (ch_num == $past(ch_num) + 7'd1) || (ch_num == 7'd0));

  p_part_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (part_b == ch_num[4]));

  p_idle_no_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !ch_en);

  p_sync_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fsync && !bit_en |=> $stable(active));
endmodule

bind tdm_two_part_sel tps_chk u_chk_rx (
  .clk(clk), .rst_n(rst_n), .bit_en(rx_bit_en), .fsync(rx_fsync),
  .active(rx_active), .ch_num(rx_ch_num), .part_b(rx_part_b), .ch_en(rx_ch_en)
);

bind tdm_two_part_sel tps_chk u_chk_tx (
  .clk(clk), .rst_n(rst_n), .bit_en(tx_bit_en), .fsync(tx_fsync),
  .active(tx_active), .ch_num(tx_ch_num), .part_b(tx_part_b), .ch_en(tx_ch_en)
);

// File: tb/test_tdm_two_part_sel.sv
module test_tdm_two_part_sel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        rx_bit_en = 0, rx_fsync = 0, tx_bit_en = 0, tx_fsync = 0;
  logic [4:0]  rx_wl = 0, tx_wl = 0;
  logic [6:0]  rx_fl = 0, tx_fl = 0;
  logic [2:0]  rx_ba = 0, rx_bb = 0, tx_ba = 0, tx_bb = 0;
  logic [15:0] rx_ma = 0, rx_mb = 0, tx_ma = 0, tx_mb = 0;
  logic        rx_active, rx_part_b, rx_ch_en, tx_active, tx_part_b, tx_ch_en;
  logic [6:0]  rx_ch_num, tx_ch_num;

  int n_chk = 0;
  int n_bad = 0;

  tdm_two_part_sel i_tdm_two_part_sel (
    .clk(clk), .rst_n(rst_n),
    .rx_bit_en(rx_bit_en), .rx_fsync(rx_fsync), .rx_word_len_m1(rx_wl),
    .rx_frame_len_m1(rx_fl), .rx_blk_a(rx_ba), .rx_blk_b(rx_bb),
    .rx_mask_a(rx_ma), .rx_mask_b(rx_mb),
    .rx_active(rx_active), .rx_ch_num(rx_ch_num), .rx_part_b(rx_part_b), .rx_ch_en(rx_ch_en),
    .tx_bit_en(tx_bit_en), .tx_fsync(tx_fsync), .tx_word_len_m1(tx_wl),
    .tx_frame_len_m1(tx_fl), .tx_blk_a(tx_ba), .tx_blk_b(tx_bb),
    .tx_mask_a(tx_ma), .tx_mask_b(tx_mb),
    .tx_active(tx_active), .tx_ch_num(tx_ch_num), .tx_part_b(tx_part_b), .tx_ch_en(tx_ch_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int d, input logic be, input logic fs);
    if (d == 0) begin rx_bit_en = be; rx_fsync = fs; end
    else        begin tx_bit_en = be; tx_fsync = fs; end
  endtask

  // compare one direction against the bit index k since the frame sync
  task automatic expect_bit(input int d, input int k, input int w, input int nch,
                            input int ba, input int bb, input int ma, input int mb);
    int ch, blk, pb, abl, bbl, en;
    logic act; logic [6:0] cn; logic p, e;
    if (d == 0) begin act = rx_active; cn = rx_ch_num; p = rx_part_b; e = rx_ch_en; end
    else        begin act = tx_active; cn = tx_ch_num; p = tx_part_b; e = tx_ch_en; end
    ch = k / w;
    if (ch >= nch) begin
      chk("R5 active after frame end", act, 0);
      chk("R5 ch_en while idle", e, 0);
    end else begin
      blk = ch / 16;
      pb  = blk % 2;
      abl = (ba / 2) * 2;
      bbl = (bb / 2) * 2 + 1;
      en  = ((pb == 0) ? (blk == abl ? (ma >> (ch % 16)) & 1 : 0)
                       : (blk == bbl ? (mb >> (ch % 16)) & 1 : 0));
      chk("R2 active in frame", act, 1);
      chk("R3 ch_num", cn, ch);
      chk("R4 partition", p, pb);
      chk(((blk != abl) && (blk != bbl)) ? "R8 unselected block" : "R7 ch_en", e, en);
    end
  endtask

  // run a frame on one direction; gap inserts idle strobes, restart_k re-syncs
  task automatic run(input int d, input int wlm1, input int flm1,
                     input int ba, input int bb, input int ma, input int mb,
                     input int nbits, input bit gap, input int restart_k);
    int k;
    bit restarted;
    restarted = 0;
    if (d == 0) begin rx_wl = wlm1[4:0]; rx_fl = flm1[6:0]; rx_ba = ba[2:0]; rx_bb = bb[2:0];
                      rx_ma = ma[15:0]; rx_mb = mb[15:0]; end
    else        begin tx_wl = wlm1[4:0]; tx_fl = flm1[6:0]; tx_ba = ba[2:0]; tx_bb = bb[2:0];
                      tx_ma = ma[15:0]; tx_mb = mb[15:0]; end
    drive(d, 1, 1);
    @(negedge clk);
    k = 0;
    while (k < nbits) begin
      expect_bit(d, k, wlm1 + 1, flm1 + 1, ba, bb, ma, mb);
      if (gap) begin
        drive(d, 0, (k % 3) == 0);  // R10: sync without strobe is ignored
        @(negedge clk);
        expect_bit(d, k, wlm1 + 1, flm1 + 1, ba, bb, ma, mb);
      end
      if (!restarted && k == restart_k) begin
        drive(d, 1, 1);             // R6: mid-frame restart
        restarted = 1;
        k = 0;
      end else begin
        drive(d, 1, 0);
        k++;
      end
      @(negedge clk);
    end
    drive(d, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 rx_active in reset", rx_active, 0);
    chk("R1 rx_ch_num in reset", rx_ch_num, 0);
    chk("R1 tx_part_b in reset", tx_part_b, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rx_ch_en after reset", rx_ch_en, 0);
    chk("R1 tx_active after reset", tx_active, 0);

    // R10: sync without strobe leaves the direction idle
    rx_fsync = 1'b1;
    @(negedge clk);
    rx_fsync = 1'b0;
    @(negedge clk);
    chk("R10 sync without bit_en", rx_active, 0);

    // full 128-channel sweep of block selects on rx (2-bit slots)
    for (int sa = 0; sa < 8; sa++) begin
      run(0, 1, 127, sa, 7 - sa, 16'hA5C3 ^ (sa * 16'h1111), 16'h3C5A + sa, 258, 0, -1);
      // R9: tx untouched while rx runs
      chk("R9 tx idle during rx", tx_active, 0);
      chk("R9 tx ch_num during rx", tx_ch_num, 0);
    end

    // tx with 3-bit slots, short frame, strobe gaps
    run(1, 2, 39, 2, 5, 16'hFFFF, 16'h8001, 125, 1, -1);
    chk("R9 rx idle during tx", rx_active, 0);
    // tx mid-frame restart while in partition B (channel 20)
    run(1, 0, 63, 0, 1, 16'h00FF, 16'hF0F0, 70, 0, 20);
    // full-mask rx frame, frame ending inside partition B
    run(0, 3, 24, 6, 3, 16'hFFFF, 16'hFFFF, 104, 0, -1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule